// File: doc/BRIEF.md
# Front-End Power-Up Configuration Sequencer

This block sits on the host side of a frame-based serial link to a modem analog front end. On leaving system reset it holds the front end's active-low reset line low for a fixed pulse. It then waits out the oscillator and PLL settling time. After that it hands a fixed run of 16-bit words, one at a time, to a serial frame shifter through a valid/ready word handshake. The run first puts the link into a known frame phase. It then writes the front end's configuration registers. Each write is paired with the data word the current control mode expects.

A build-time parameter selects one of two control styles. In the request style, every control word is preceded by a data word whose bit 0 is set, which asks for the next frame to be a control frame. In the alternating style, the enable write also sets the mode bit that makes frames alternate on their own. Every later control word is then preceded by an all-zero filler data word. Once the last table word has been accepted, the block raises `done` and passes the host's transmit samples to the shifter with bit 0 cleared, so that no control frame is requested.

The FSM has four states. ST_HOLD_RST drives the reset pulse. When the timer expires it moves to ST_SETTLE, which counts the settling delay. When that timer expires it moves to ST_ISSUE, which walks the table one handshake at a time. When the last entry is accepted it moves to ST_RUN, the pass-through state, and stays there. An assertion of `rst_n` returns the FSM from any state to ST_HOLD_RST.

Top module: `afe_boot_seq`

## Requirements
- R1: After `rst_n` is released, `fe_rst_n` stays low for exactly ceil(RST_NS × CLK_KHZ / 10^6) clock cycles (13 with the defaults). It then goes high and stays high until the next `rst_n` assertion.
- R2: `word_valid` stays low for exactly SETTLE_US × CLK_KHZ / 1000 cycles (12500 with the defaults) after `fe_rst_n` rises. It is never high while `fe_rst_n` is low.
- R3: A control word is {bit15 read flag (1 = read), bits 14:8 register address, bits 7:0 value}. The first two words are both 0x0100: two writes of 0x00 to register 0x01, which clear its mode bit (bit 0).
- R4: With HW_CTRL = 0, words 2 to 25 alternate between data word 0x0001 and a control word. The control words in order are 0x0D00, 0x0180, 0x0200, 0x03D0, 0x0800, 0x090A, 0x0A11, 0x0B0F, 0x0C00, 0x8200, 0x8200 and 0x0DC0.
- R5: With HW_CTRL = 1, the enable write (word 5) is 0x0181, which sets the mode bit. The data words before the first two control words are 0x0001. Every data word after the enable write (words 6, 8, …, 24) is 0x0000.
- R6: The table ends with two reads of register 0x02 (0x8200 twice), followed by the final write of 0xC0 to register 0x0D. The table holds 26 words.
- R7: While `word_valid` is high and `word_ready` is low during the sequence, `word_data` holds its value. The table advances by exactly one word per cycle with both high.
- R8: `busy` is high, and `done` low, from reset until the cycle after the last table word is accepted. From then on `done` is high and `busy` low until the next reset.
- R9: After `done`, `word_valid` is high and `word_data` equals `tx_sample` with bit 0 forced to 0.
- R10: Asserting `rst_n` at any point, including in the middle of the table, forces `fe_rst_n` low, `word_valid` low, `busy` high and `done` low. On release the sequence restarts from the reset pulse and word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| word_ready | input | 1 | Shifter accepts the presented word this cycle |
| tx_sample | input | 16 | Host transmit sample used after the table is finished |
| fe_rst_n | output | 1 | Active-low reset to the front end |
| word_valid | output | 1 | A word is presented to the shifter |
| word_data | output | 16 | Word presented to the shifter |
| busy | output | 1 | Power-up sequence in progress |
| done | output | 1 | Table finished; pass-through active |

## Verification
The bench measures the reset pulse and the settle window to the exact cycle. A counter that is off by one, or that reloads in the wrong state, shows up as a length of 12 or 14 instead of 13, or a first word one cycle early. Both control styles walk the same 26-word table side by side, with ready withheld on some words. A wrong filler word after the enable write, a missing mode bit, or a word that advances without a handshake shows up as a mismatch at a known index. The bench also checks that bit 0 is cleared in pass-through, which catches a stray control request. A reset in the middle of the table must restart at word 0 and not resume at the old index.

// File: rtl/afe_seq_pkg.sv
package afe_seq_pkg;

    localparam int WORD_W = 16;
    localparam int PAIRS  = 12;
    localparam int DEPTH  = 2 + 2 * PAIRS;

    typedef logic [WORD_W-1:0] fe_word_t;

    typedef enum logic [1:0] {
        ST_HOLD_RST,
        ST_SETTLE,
        ST_ISSUE,
        ST_RUN
    } seq_state_t;

    // Control word layout: read flag, 7-bit register address, 8-bit value.
    function automatic fe_word_t ctrl_word(input logic rd, input logic [6:0] addr,
                                           input logic [7:0] val);
        return {rd, addr, val};
    endfunction

    // Configuration control word for pair k; hc selects the alternating style.
    function automatic fe_word_t cfg_entry(input int k, input logic hc);
        fe_word_t w;
        case (k)
            0:       w = ctrl_word(1'b0, 7'h0D, 8'h00);
            1:       w = ctrl_word(1'b0, 7'h01, {7'b1000000, hc});
            2:       w = ctrl_word(1'b0, 7'h02, 8'h00);
            3:       w = ctrl_word(1'b0, 7'h03, 8'hD0);
            4:       w = ctrl_word(1'b0, 7'h08, 8'h00);
            5:       w = ctrl_word(1'b0, 7'h09, 8'h0A);
            6:       w = ctrl_word(1'b0, 7'h0A, 8'h11);
            7:       w = ctrl_word(1'b0, 7'h0B, 8'h0F);
            8:       w = ctrl_word(1'b0, 7'h0C, 8'h00);
            9:       w = ctrl_word(1'b1, 7'h02, 8'h00);
            10:      w = ctrl_word(1'b1, 7'h02, 8'h00);
            11:      w = ctrl_word(1'b0, 7'h0D, 8'hC0);
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/afe_seq_timer.sv
module afe_seq_timer #(
    parameter int CNT_W = 14,
    parameter int INIT  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/afe_seq_rom.sv
module afe_seq_rom
    import afe_seq_pkg::*;
#(
    parameter bit HW_CTRL = 1'b0,
    parameter int IDX_W   = 5
) (
    input  logic [IDX_W-1:0] idx,
    output fe_word_t         word
);

    logic [IDX_W-1:0] pair_k;
    fe_word_t         pad;

    assign pair_k = (idx - IDX_W'(2)) >> 1;

    generate
        if (HW_CTRL) begin : g_alt
            // Filler words are zero once the alternating mode bit is written.
            assign pad = (pair_k >= IDX_W'(2)) ? fe_word_t'(16'h0000) : fe_word_t'(16'h0001);
        end else begin : g_req
            assign pad = fe_word_t'(16'h0001);
        end
    endgenerate

    always_comb begin
        if (idx < IDX_W'(2)) begin
            word = ctrl_word(1'b0, 7'h01, 8'h00);
        end else if (!idx[0]) begin
            word = pad;
        end else begin
            word = cfg_entry(int'(pair_k), HW_CTRL);
        end
    end

endmodule

// File: rtl/afe_boot_seq.sv
module afe_boot_seq
    import afe_seq_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int RST_NS    = 100,
    parameter int SETTLE_US = 100,
    parameter bit HW_CTRL   = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_ready,
    input  logic [15:0] tx_sample,
    output logic        fe_rst_n,
    output logic        word_valid,
    output logic [15:0] word_data,
    output logic        busy,
    output logic        done
);

    localparam int RST_RAW       = (RST_NS * CLK_KHZ + 999_999) / 1_000_000;
    localparam int RST_CYCLES    = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int SETTLE_RAW    = SETTLE_US * CLK_KHZ / 1000;
    localparam int SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int TMAX          = (SETTLE_CYCLES > RST_CYCLES) ? SETTLE_CYCLES : RST_CYCLES;
    localparam int CNT_W         = $clog2(TMAX + 1);
    localparam int IDX_W         = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             tmr_zero;
    logic             tmr_load;
    fe_word_t         rom_word;
    logic             take;

    afe_seq_timer #(
        .CNT_W (CNT_W),
        .INIT  (RST_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (CNT_W'(SETTLE_CYCLES - 1)),
        .zero     (tmr_zero)
    );

    afe_seq_rom #(
        .HW_CTRL (HW_CTRL),
        .IDX_W   (IDX_W)
    ) u_rom (
        .idx  (idx_q),
        .word (rom_word)
    );

    assign tmr_load = (state_q == ST_HOLD_RST) && tmr_zero;
    assign take     = (state_q == ST_ISSUE) && word_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD_RST: if (tmr_zero) state_d = ST_SETTLE;
            ST_SETTLE:   if (tmr_zero) state_d = ST_ISSUE;
            ST_ISSUE:    if (word_ready && (idx_q == LAST_IDX)) state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
        endcase
    end

    // Table index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (take && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        fe_rst_n   = 1'b1;
        word_valid = 1'b0;
        word_data  = '0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_HOLD_RST: fe_rst_n = 1'b0;
            ST_SETTLE:   ;
            ST_ISSUE: begin
                word_valid = 1'b1;
                word_data  = rom_word;
            end
            ST_RUN: begin
                word_valid = 1'b1;
                word_data  = tx_sample & 16'hFFFE;
                busy       = 1'b0;
                done       = 1'b1;
            end
        endcase
    end

    AST_FE_RST_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fe_rst_n |=> fe_rst_n); // R1
    AST_NO_WORD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> fe_rst_n); // R2
    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX); // R6
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready && busy) |=> (word_valid && $stable(word_data))); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !busy)); // R8
    AST_RUN_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_valid) |-> !word_data[0]); // R9

endmodule

// File: tb/afe_boot_seq_bench.sv
module afe_boot_seq_bench;

    localparam int RST_EXP    = 13;
    localparam int SETTLE_EXP = 12500;
    localparam logic [15:0] EXP_SW [26] = '{
        16'h0100, 16'h0100,
        16'h0001, 16'h0D00, 16'h0001, 16'h0180, 16'h0001, 16'h0200,
        16'h0001, 16'h03D0, 16'h0001, 16'h0800, 16'h0001, 16'h090A,
        16'h0001, 16'h0A11, 16'h0001, 16'h0B0F, 16'h0001, 16'h0C00,
        16'h0001, 16'h8200, 16'h0001, 16'h8200, 16'h0001, 16'h0DC0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_ready = 1'b0;
    logic [15:0] tx_sample = 16'h0000;
    logic        fe_rst_n, word_valid, busy, done;
    logic [15:0] word_data;
    logic        fe_rst_n_h, word_valid_h, busy_h, done_h;
    logic [15:0] word_data_h;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    afe_boot_seq #(.HW_CTRL(1'b0)) u_afe_boot_seq (
        .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .tx_sample(tx_sample),
        .fe_rst_n(fe_rst_n), .word_valid(word_valid), .word_data(word_data),
        .busy(busy), .done(done));

    afe_boot_seq #(.HW_CTRL(1'b1)) u_afe_boot_seq_hw (
        .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .tx_sample(tx_sample),
        .fe_rst_n(fe_rst_n_h), .word_valid(word_valid_h), .word_data(word_data_h),
        .busy(busy_h), .done(done_h));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_hw(input int i);
        if (i == 5) return 16'h0181;
        if (i >= 6 && (i % 2) == 0) return 16'h0000;
        return EXP_SW[i];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Release reset and measure reset pulse and settle window (R1, R2)
    task automatic boot_and_measure();
        int n;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!fe_rst_n && n < 100) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == RST_EXP, "R1 reset pulse length", n, RST_EXP);
        n = 0;
        while (!word_valid && n < 20000) begin
            chk(fe_rst_n, "R1 fe_rst_n stays high", fe_rst_n, 1);
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == SETTLE_EXP, "R2 settle length", n, SETTLE_EXP);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual running expected finished");
        summary();
    end

    initial begin
        // Reset state (R10)
        repeat (3) @(negedge clk);
        chk(!fe_rst_n && !word_valid, "R10 reset state fe/valid", {fe_rst_n, word_valid}, 0);
        chk(busy && !done, "R10 reset state busy/done", {busy, done}, 2);
        chk(word_valid == word_valid_h, "R2 both styles idle", word_valid_h, word_valid);

        boot_and_measure();
        chk(word_valid_h, "R2 alternating style ready same cycle", word_valid_h, 1);

        // Walk the table in both styles (R3 to R8)
        for (int i = 0; i < 26; i++) begin
            chk(word_data == EXP_SW[i], (i < 2) ? "R3 mode clear" : (i >= 21 ? "R6 tail" : "R4 request style"),
                word_data, EXP_SW[i]);
            chk(word_data_h == exp_hw(i), "R5 alternating style", word_data_h, exp_hw(i));
            chk(busy && !done, "R8 busy during table", {busy, done}, 2);
            if (i % 3 == 0) begin
                @(negedge clk);
                chk(word_valid && word_data == EXP_SW[i], "R7 stall holds word", word_data, EXP_SW[i]);
            end
            word_ready = 1'b1;
            @(negedge clk);
            word_ready = 1'b0;
        end
        chk(done && !busy, "R8 done after last word", {busy, done}, 1);
        chk(done_h && !busy_h, "R8 done alternating", {busy_h, done_h}, 1);

        // Pass-through (R9)
        tx_sample = 16'hABCD;
        @(negedge clk);
        chk(word_valid && word_data == 16'hABCC, "R9 pass-through odd", word_data, 16'hABCC);
        tx_sample = 16'h1234;
        word_ready = 1'b1;
        @(negedge clk);
        word_ready = 1'b0;
        chk(word_data == 16'h1234 && done, "R9 pass-through even", word_data, 16'h1234);
        chk(done, "R8 done sticky", done, 1);

        // Reset after done, then mid-table reset (R10)
        rst_n = 1'b0;
        @(negedge clk);
        chk(!fe_rst_n && !word_valid && busy && !done, "R10 reset after done",
            {fe_rst_n, word_valid, busy, done}, 2);
        boot_and_measure();
        for (int i = 0; i < 3; i++) begin
            word_ready = 1'b1;
            @(negedge clk);
        end
        word_ready = 1'b0;
        chk(word_data == EXP_SW[3], "R7 three handshakes advance three", word_data, EXP_SW[3]);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!fe_rst_n && !word_valid && busy, "R10 mid-table reset", {fe_rst_n, word_valid, busy}, 1);
        boot_and_measure();
        chk(word_data == 16'h0100, "R10 restart at word 0", word_data, 16'h0100);

        summary();
    end

endmodule